// File: doc/BRIEF.md
# Two-Wire Slave Command Front End

This block is the bus-facing half of a dual digital-potentiometer controller. A fast system clock samples the serial clock and data lines through a short synchronizer. The block then detects start and stop conditions and matches an 8-bit slave address. It decodes a one-byte instruction and either accepts or returns a 6-bit data byte. The data line is driven open drain: the block only ever pulls it low.

Decoded commands go to a register bank as a one-cycle pulse carrying the opcode, register select, pot select and data. Reads take their value from the bank through `rd_data_i`, which is addressed by the held selects. The bank reports a busy flag while a nonvolatile write is in progress. While that flag is set, the block refuses to acknowledge its address, so a host can poll for completion.

A streaming step mode turns each complete serial-clock pulse into a one-cycle wiper step. The direction of each step follows the data level during that pulse.

Top module: `tws_front`

## Requirements
- R1: A start (data falling while clock high) at any point aborts the current transfer and begins a new address byte. A stop (data rising while clock high) always returns the block to idle.
- R2: The address byte is acknowledged only when its upper nibble is 0101 and its lower nibble equals `dev_addr_i`, sent MSB first. After a mismatch, no later byte of that transfer is acknowledged.
- R3: While `busy_i` is high when the address byte completes, the address is not acknowledged.
- R4: The instruction byte is always acknowledged. Bits 7:4 are the opcode, bits 3:2 the register select and bits 1:0 the pot select, all presented on `cmd_*_o`. An opcode outside the nine defined ones produces no command, and no later byte of that transfer is acknowledged.
- R5: Write opcodes 1010 (live register) and 1100 (bank register) take one data byte and acknowledge it. Bits 5:0 of that byte are the data and bits 7:6 are discarded. The command pulse is issued at the falling clock edge that ends the data acknowledge.
- R6: Read opcodes 1001 and 1011 return, MSB first, two zero bits followed by the 6-bit `rd_data_i`, captured when the instruction acknowledge ends. No command pulse is issued.
- R7: Transfer opcodes 1101, 1110, 0001 and 1000 issue their command pulse only at the stop that follows the instruction acknowledge. A repeated start before that stop cancels them.
- R8: After opcode 0010, each complete clock-high pulse produces one `step_o` pulse. `step_up_o` is 1 when data was high during the pulse and 0 when it was low. The high phase that ends in the stop produces no step.
- R9: A stop in the middle of a data byte discards the partial command, and no pulse is issued.
- R10: `sda_oe_o` is low in idle and is only asserted during acknowledge bits and the zero bits of read data. `cmd_valid_o` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| dev_addr_i | input | 4 | Strap value for the low address nibble |
| busy_i | input | 1 | Register bank nonvolatile write in progress |
| rd_data_i | input | 6 | Register value selected by cmd_reg_o/cmd_pot_o |
| cmd_valid_o | output | 1 | One-cycle command pulse |
| cmd_op_o | output | 4 | Opcode of the last instruction |
| cmd_reg_o | output | 2 | Register select of the last instruction |
| cmd_pot_o | output | 2 | Pot select of the last instruction |
| cmd_data_o | output | 6 | Data of the last write |
| step_o | output | 1 | One-cycle wiper step pulse |
| step_up_o | output | 1 | Step direction, 1 towards the high terminal |

## Verification
The bench sweeps all 256 address bytes against a fixed strap and every strap value against a matching byte. A comparator off by a bit, or checked in the wrong bit order, would then acknowledge a wrong address or miss its own. It checks that transfer commands wait for the stop: a design that fired at the instruction acknowledge would show a pulse too early, and one that ignored a repeated start would execute a cancelled transfer. In step mode it closes with a stop after a low-data pulse, which catches a design that counts the stop's own high phase as an extra down step. It also aborts a write halfway through a byte and drives an unknown opcode, expecting silence on the command port and no acknowledge on the following byte.

// File: rtl/tws_pkg.sv
package tws_pkg;
  localparam int BYTE_W = 8;
  localparam int OP_W   = 4;
  localparam int SEL_W  = 2;

  localparam logic [OP_W-1:0] OP_RD_LIVE  = 4'b1001;
  localparam logic [OP_W-1:0] OP_WR_LIVE  = 4'b1010;
  localparam logic [OP_W-1:0] OP_RD_BANK  = 4'b1011;
  localparam logic [OP_W-1:0] OP_WR_BANK  = 4'b1100;
  localparam logic [OP_W-1:0] OP_LOAD     = 4'b1101;
  localparam logic [OP_W-1:0] OP_SAVE     = 4'b1110;
  localparam logic [OP_W-1:0] OP_LOAD_ALL = 4'b0001;
  localparam logic [OP_W-1:0] OP_SAVE_ALL = 4'b1000;
  localparam logic [OP_W-1:0] OP_STEP     = 4'b0010;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_INSTR, ST_IACK, ST_WDATA,
    ST_DACK, ST_RDATA, ST_STEP, ST_PEND, ST_IGNORE
  } st_e;
endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic rise_o,
  output logic fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p;
  logic scl_s, sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_p <= scl_q[STAGES-1];
      sda_p <= sda_q[STAGES-1];
    end
  end

  assign scl_s   = scl_q[STAGES-1];
  assign sda_s   = sda_q[STAGES-1];
  assign sda_o   = sda_s;
  assign rise_o  = scl_s & ~scl_p;
  assign fall_o  = ~scl_s & scl_p;
  assign start_o = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_o  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/tws_ctrl.sv
module tws_ctrl
  import tws_pkg::*;
#(
  parameter logic [3:0] DEV_TYPE = 4'b0101,
  parameter int DATA_W = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sda_i,
  input  logic                rise_i,
  input  logic                fall_i,
  input  logic                start_i,
  input  logic                stop_i,
  input  logic [3:0]          dev_addr_i,
  input  logic                busy_i,
  input  logic [DATA_W-1:0]   rd_data_i,
  output logic                sda_oe_o,
  output logic                cmd_valid_o,
  output logic [OP_W-1:0]     cmd_op_o,
  output logic [SEL_W-1:0]    cmd_reg_o,
  output logic [SEL_W-1:0]    cmd_pot_o,
  output logic [DATA_W-1:0]   cmd_data_o,
  output logic                step_o,
  output logic                step_up_o,
  output st_e                 st_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam int PAD_W = BYTE_W - DATA_W;

  st_e               st;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh, tx;
  logic              sda_hi;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st          <= ST_IDLE;
      cnt         <= '0;
      sh          <= '0;
      tx          <= '0;
      sda_hi      <= 1'b0;
      sda_oe_o    <= 1'b0;
      cmd_valid_o <= 1'b0;
      cmd_op_o    <= '0;
      cmd_reg_o   <= '0;
      cmd_pot_o   <= '0;
      cmd_data_o  <= '0;
      step_o      <= 1'b0;
      step_up_o   <= 1'b0;
    end else begin
      cmd_valid_o <= 1'b0;
      step_o      <= 1'b0;
      if (stop_i) begin
        if (st == ST_PEND) cmd_valid_o <= 1'b1;
        st       <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else if (start_i) begin
        st       <= ST_ADDR;
        cnt      <= '0;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR, ST_INSTR, ST_WDATA: begin
            if (rise_i) begin
              sh  <= {sh[BYTE_W-2:0], sda_i};
              cnt <= cnt + 1'b1;
            end else if (fall_i && cnt == CNT_FULL) begin
              cnt <= '0;
              if (st == ST_ADDR) begin
                if (sh == {DEV_TYPE, dev_addr_i} && !busy_i) begin
                  st <= ST_AACK; sda_oe_o <= 1'b1;
                end else st <= ST_IGNORE;
              end else if (st == ST_INSTR) begin
                cmd_op_o  <= sh[7:4];
                cmd_reg_o <= sh[3:2];
                cmd_pot_o <= sh[1:0];
                st        <= ST_IACK;
                sda_oe_o  <= 1'b1;
              end else begin
                cmd_data_o <= sh[DATA_W-1:0];
                st         <= ST_DACK;
                sda_oe_o   <= 1'b1;
              end
            end
          end
          ST_AACK: if (fall_i) begin
            sda_oe_o <= 1'b0;
            st       <= ST_INSTR;
          end
          ST_IACK: if (fall_i) begin
            sda_oe_o <= 1'b0;
            case (cmd_op_o)
              OP_RD_LIVE, OP_RD_BANK: begin
                st       <= ST_RDATA;
                sda_oe_o <= 1'b1;  // first pad bit is zero
                tx       <= {{(PAD_W-1){1'b0}}, rd_data_i, 1'b0};
              end
              OP_WR_LIVE, OP_WR_BANK: st <= ST_WDATA;
              OP_STEP:                st <= ST_STEP;
              OP_LOAD, OP_SAVE, OP_LOAD_ALL, OP_SAVE_ALL: st <= ST_PEND;
              default:                st <= ST_IGNORE;
            endcase
          end
          ST_RDATA: begin
            if (rise_i) cnt <= cnt + 1'b1;
            else if (fall_i) begin
              if (cnt == CNT_FULL) begin
                sda_oe_o <= 1'b0;
                st       <= ST_IGNORE;
              end else begin
                sda_oe_o <= ~tx[BYTE_W-1];
                tx       <= {tx[BYTE_W-2:0], 1'b0};
              end
            end
          end
          ST_DACK: if (fall_i) begin
            sda_oe_o    <= 1'b0;
            cmd_valid_o <= 1'b1;
            st          <= ST_IGNORE;
          end
          ST_STEP: begin
            if (rise_i) sda_hi <= sda_i;
            else if (fall_i) begin
              step_o    <= 1'b1;
              step_up_o <= sda_hi;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign st_o = st;
endmodule

// File: rtl/tws_front.sv
module tws_front
  import tws_pkg::*;
#(
  parameter logic [3:0] DEV_TYPE    = 4'b0101,
  parameter int         DATA_W      = 6,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [3:0]        dev_addr_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              cmd_valid_o,
  output logic [OP_W-1:0]   cmd_op_o,
  output logic [SEL_W-1:0]  cmd_reg_o,
  output logic [SEL_W-1:0]  cmd_pot_o,
  output logic [DATA_W-1:0] cmd_data_o,
  output logic              step_o,
  output logic              step_up_o
);
  logic sda_s, rise, fall, start, stop;
  st_e  st;

  tws_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .rise_o(rise), .fall_o(fall), .start_o(start), .stop_o(stop)
  );

  tws_ctrl #(.DEV_TYPE(DEV_TYPE), .DATA_W(DATA_W)) i_ctrl (
    .clk_i, .rst_ni, .sda_i(sda_s), .rise_i(rise), .fall_i(fall),
    .start_i(start), .stop_i(stop), .dev_addr_i, .busy_i, .rd_data_i,
    .sda_oe_o, .cmd_valid_o, .cmd_op_o, .cmd_reg_o, .cmd_pot_o, .cmd_data_o,
    .step_o, .step_up_o, .st_o(st)
  );
endmodule

// File: rtl/tws_front_chk.sv
module tws_front_chk
  import tws_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            busy_i,
  input logic            sda_oe_o,
  input logic            cmd_valid_o,
  input logic [OP_W-1:0] cmd_op_o,
  input logic            step_o,
  input st_e             st
);
  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st == ST_IDLE |-> !sda_oe_o);  // R10
  AST_CMD_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);  // R10
  AST_BUSY_NO_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_AACK && $past(st) == ST_ADDR) |-> !$past(busy_i));  // R3
  AST_ACK_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_AACK || st == ST_IACK || st == ST_DACK) |-> sda_oe_o);  // R4
  AST_STEP_IN_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> $past(st) == ST_STEP);  // R8
  AST_NO_CMD_AND_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_valid_o && step_o));  // R8
  AST_CMD_OPCODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (cmd_op_o == OP_WR_LIVE || cmd_op_o == OP_WR_BANK ||
                     cmd_op_o == OP_LOAD || cmd_op_o == OP_SAVE ||
                     cmd_op_o == OP_LOAD_ALL || cmd_op_o == OP_SAVE_ALL));  // R7
endmodule

bind tws_front tws_front_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(busy_i), .sda_oe_o(sda_oe_o),
  .cmd_valid_o(cmd_valid_o), .cmd_op_o(cmd_op_o), .step_o(step_o), .st(st)
);

// File: tb/test_tws_front.sv
module test_tws_front;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1, busy = 1'b0;
  logic [3:0] dev = 4'hA;
  logic [5:0] rd_data = '0;
  logic sda_oe, cmd_valid, step, step_up;
  logic [3:0] cmd_op;
  logic [1:0] cmd_reg, cmd_pot;
  logic [5:0] cmd_data;
  wire  sda = sda_m & ~sda_oe;
  int checks = 0, errors = 0;
  int n_cmd = 0, n_up = 0, n_dn = 0;
  logic [3:0] l_op; logic [1:0] l_reg, l_pot; logic [5:0] l_data;

  always #2 clk = ~clk;

  tws_front i_tws_front (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda), .sda_oe_o(sda_oe),
    .dev_addr_i(dev), .busy_i(busy), .rd_data_i(rd_data),
    .cmd_valid_o(cmd_valid), .cmd_op_o(cmd_op), .cmd_reg_o(cmd_reg),
    .cmd_pot_o(cmd_pot), .cmd_data_o(cmd_data), .step_o(step), .step_up_o(step_up)
  );

  always @(negedge clk) begin
    if (cmd_valid) begin
      n_cmd++; l_op = cmd_op; l_reg = cmd_reg; l_pot = cmd_pot; l_data = cmd_data;
    end
    if (step) begin
      if (step_up) n_up++; else n_dn++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  task automatic bit_out(input logic b);
    sda_m = b; w(4); scl = 1'b1; w(8); scl = 1'b0; w(4);
  endtask

  task automatic start_c; sda_m = 1'b1; w(4); scl = 1'b1; w(6); sda_m = 1'b0; w(6); scl = 1'b0; w(4); endtask
  task automatic stop_c;  sda_m = 1'b0; w(4); scl = 1'b1; w(6); sda_m = 1'b1; w(8); endtask

  task automatic send(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    sda_m = 1'b1; w(4); scl = 1'b1; w(4); ack = sda_oe; w(4); scl = 1'b0; w(4);
  endtask

  task automatic recv(output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; w(4); scl = 1'b1; w(4); b[i] = sda; w(4); scl = 1'b0; w(4);
    end
    bit_out(1'b0);
  endtask

  task automatic header(input logic [7:0] ins, output bit aa, output bit ai);
    start_c; send({4'b0101, dev}, aa); send(ins, ai);
  endtask

  task automatic finish_sim;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim;
  end

  initial begin
    bit aa, ai, ad;
    logic [7:0] rb;
    int c0;
    w(5); rst_n = 1'b1; w(5);
    chk(sda_oe == 1'b0 && cmd_valid == 1'b0 && step == 1'b0, "R10 reset", sda_oe, 0);

    // R2: every address byte against strap A
    for (int a = 0; a < 256; a++) begin
      start_c; send(8'(a), aa); stop_c;
      chk(aa == (a == 8'h5A), "R2 address sweep", aa, a == 8'h5A);
    end
    // R2: every strap value
    for (int d = 0; d < 16; d++) begin
      dev = 4'(d); start_c; send({4'b0101, dev}, aa); stop_c;
      chk(aa, "R2 strap sweep", aa, 1);
    end
    dev = 4'h6;

    // R2: after mismatch, following byte not acknowledged
    start_c; send(8'h57, aa); send(8'hA1, ai); stop_c;
    chk(!aa && !ai, "R2 mismatch silences transfer", {aa, ai}, 0);

    // R1: repeated start after mismatch re-arms address
    start_c; send(8'h50, aa); start_c; send({4'b0101, dev}, ai); stop_c;
    chk(!aa && ai, "R1 repeated start", {aa, ai}, 1);

    // R3: busy blocks the address ack
    busy = 1'b1; start_c; send({4'b0101, dev}, aa); stop_c; busy = 1'b0;
    chk(!aa, "R3 busy no ack", aa, 0);
    start_c; send({4'b0101, dev}, aa); stop_c;
    chk(aa, "R3 ack after busy clears", aa, 1);

    // R5: write live register, pot 1, data 0x2B with bits 7:6 set
    c0 = n_cmd;
    header(8'b1010_00_01, aa, ai); send(8'hEB, ad);
    w(2);
    chk(aa && ai && ad, "R5 write acks", {aa, ai, ad}, 7);
    chk(n_cmd == c0 + 1 && l_op == 4'b1010 && l_pot == 2'd1 && l_data == 6'h2B,
        "R5 write live fields", {l_op, l_pot, l_data}, {4'b1010, 2'd1, 6'h2B});
    send(8'h11, ad); stop_c;
    chk(!ad && n_cmd == c0 + 1, "R5 extra byte ignored", ad, 0);

    // R5: write bank register 2, pot 3
    c0 = n_cmd;
    header(8'b1100_10_11, aa, ai); send(8'h15, ad); stop_c;
    chk(n_cmd == c0 + 1 && l_op == 4'b1100 && l_reg == 2'd2 && l_pot == 2'd3 && l_data == 6'h15,
        "R5 write bank fields", {l_op, l_reg, l_pot, l_data}, {4'b1100, 2'd2, 2'd3, 6'h15});

    // R6: reads, several patterns
    foreach (rb[i]) ;
    for (int k = 0; k < 4; k++) begin
      logic [5:0] v;
      v = 6'(k * 21 + 6'h0A);
      rd_data = v; c0 = n_cmd;
      header((k[0] ? 8'b1011_00_00 : 8'b1001_00_00) | 8'(k), aa, ai);
      chk(cmd_pot == 2'(k), "R6 select presented", cmd_pot, k);
      recv(rb); stop_c;
      chk(aa && ai && rb == {2'b00, v}, "R6 read data", rb, {2'b00, v});
      chk(n_cmd == c0, "R6 no command on read", n_cmd, c0);
    end
    rd_data = 6'h3F;
    header(8'b1011_11_01, aa, ai); recv(rb); stop_c;
    chk(rb == 8'h3F, "R6 read all ones", rb, 8'h3F);

    // R7: transfers execute at stop only
    for (int k = 0; k < 4; k++) begin
      logic [3:0] op;
      op = (k == 0) ? 4'b1101 : (k == 1) ? 4'b1110 : (k == 2) ? 4'b0001 : 4'b1000;
      c0 = n_cmd;
      header({op, 2'(k), 2'(3 - k)}, aa, ai); w(20);
      chk(ai && n_cmd == c0, "R7 no pulse before stop", n_cmd, c0);
      stop_c;
      chk(n_cmd == c0 + 1 && l_op == op && l_reg == 2'(k) && l_pot == 2'(3 - k),
          "R7 transfer at stop", {l_op, l_reg, l_pot}, {op, 2'(k), 2'(3 - k)});
    end
    c0 = n_cmd;
    header(8'b1101_01_00, aa, ai); start_c; stop_c;
    chk(n_cmd == c0, "R7 repeated start cancels", n_cmd, c0);

    // R8: streaming steps, last pulse low then stop
    n_up = 0; n_dn = 0;
    header(8'b0010_00_01, aa, ai);
    bit_out(1); bit_out(1); bit_out(0); bit_out(1); bit_out(0);
    w(4);
    chk(n_up == 3 && n_dn == 2, "R8 step counts", {n_up[7:0], n_dn[7:0]}, {8'd3, 8'd2});
    stop_c;
    chk(n_up == 3 && n_dn == 2, "R8 stop adds no step", n_dn, 2);

    // R4: unknown opcode acked, then silent
    c0 = n_cmd;
    header(8'b0111_00_00, aa, ai); send(8'h05, ad); stop_c;
    chk(ai && !ad && n_cmd == c0, "R4 unknown opcode", {ai, ad}, 2);

    // R9: stop inside data byte
    c0 = n_cmd;
    header(8'b1010_00_00, aa, ai);
    bit_out(0); bit_out(0); bit_out(1); bit_out(1); stop_c;
    chk(n_cmd == c0, "R9 partial byte discarded", n_cmd, c0);
    chk(sda_oe == 1'b0, "R10 released after transfer", sda_oe, 0);

    finish_sim;
  end
endmodule